// File: doc/BRIEF.md
# Multi-policy register field

This block holds one register field of configurable width. What a write or a read does to the stored value is chosen while it runs, by a policy code. Plain storage is one choice. Others make a write clear, set or toggle bits, make a read clear or fill the field, or accept only the first write after reset. Some policies combine one effect on write with a different effect on read.

A second input gives the rights of the bus the access arrives on. These rights can narrow the selected policy. On a read-only bus a write-capable field behaves as read-only, read-clear, read-set or inaccessible. On a write-only bus a read side effect is dropped or the field becomes inaccessible.

The field is meant to be placed inside a register decoder. The decoder supplies the strobes, the data, a byte-enable bit and the two codes, and takes back the read data and the stored value.

Top module: `multi_policy_field`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) loads `RESET_VAL` into the field and clears the written-once flag, so a write-once field accepts a write again afterwards.
- R2: With full rights (`rights`=0), a write loads the write data for policy codes 0 (read-write), 6 (write, read clears), 7 (write, read sets) and 20 (write-only). It loads all zeros for codes 4 and 21, and all ones for codes 5 and 22.
- R3: With full rights, the bitwise write policies give the following next values, each masked to the field width: code 10 gives cur&~d, code 11 gives cur|d, code 12 gives cur^d, code 13 gives cur&d, code 14 gives cur|~d, code 15 gives cur^~d.
- R4: On write, the combined policies act as follows: code 16 acts like 11, code 18 like 14, code 17 like 10 and code 19 like 13. Code 8 writes all ones and code 9 writes all zeros.
- R5: A read clears the field for codes 2, 6, 8, 16 and 18, and sets it to all ones for codes 3, 7, 9, 17 and 19. Codes 1, 2 and 3 ignore writes.
- R6: Codes 23 (readable) and 24 (write-only) take only the first write that reaches the field after reset. Later writes leave the value unchanged.
- R7: `rdData` is zero when `rdStb` is low. It is also zero, with no side effect, for codes 20, 21, 22 and 24 and for any access that resolves to no access.
- R8: With read-only rights (`rights`=1), the policy is narrowed as follows. Codes 0, 1, 4, 5, 10 to 15 and 23 become read-only. Codes 2, 6, 8, 16 and 18 become read-clear. Codes 3, 7, 9, 17 and 19 become read-set. Codes 20, 21, 22 and 24 become no access.
- R9: With write-only rights (`rights`=2), the policy is narrowed as follows. Codes 0, 6 and 7 become write-only. Codes 16, 18, 17, 19, 9 and 8 become codes 11, 14, 10, 13, 4 and 5. Codes 1, 2 and 3 become no access. `rights`=3 always gives no access.
- R10: Policy codes 25 to 31 are illegal. They behave as code 0, before the rights narrowing, and drive `illegalPolicy` high in the same cycle.
- R11: A write with `wrByteEn` low leaves the field unchanged.
- R12: The stored value changes only on the clock edge after the strobe. `rdData` shows the value before that update. When a read and a write arrive together, the read side effect is applied first and the write effect second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| polSel | input | 5 | Access policy code |
| rights | input | 2 | Bus rights: 0 full, 1 read-only, 2 write-only, 3 none |
| wrStb | input | 1 | Write strobe |
| wrData | input | WIDTH | Write data |
| wrByteEn | input | 1 | Byte enable covering the field |
| rdStb | input | 1 | Read strobe |
| rdData | output | WIDTH | Read data, combinational |
| fieldValue | output | WIDTH | Current stored value |
| illegalPolicy | output | 1 | Unrecognised policy code present |

## Verification
The assertions check on every cycle the properties that need no history. A field on a read-only bus with no read does not move. A write with the byte enable low changes nothing. Hidden reads return zero, plain reads show the stored value, read-clear and read-set land on their fixed values, and an illegal code stores the write data. The arithmetic of each bitwise policy, the write-once acceptance across resets, the ordering of a read and a write in the same cycle, and the full narrowing table for each rights value depend on a preloaded value and a sequence of accesses. Only the bench's scenarios show those.

// File: rtl/mpf_pkg.sv
package mpf_pkg;

  localparam int unsigned POL_W        = 5;
  localparam int unsigned NUM_POLICIES = 25;

  typedef enum logic [POL_W-1:0] {
    P_RDWR          = 5'd0,
    P_RDONLY        = 5'd1,
    P_RDCLR         = 5'd2,
    P_RDSET         = 5'd3,
    P_WRZEROS       = 5'd4,
    P_WRONES        = 5'd5,
    P_WR_RDCLR      = 5'd6,
    P_WR_RDSET      = 5'd7,
    P_ONES_RDCLR    = 5'd8,
    P_ZEROS_RDSET   = 5'd9,
    P_ONE_CLR       = 5'd10,
    P_ONE_SET       = 5'd11,
    P_ONE_TOG       = 5'd12,
    P_ZERO_CLR      = 5'd13,
    P_ZERO_SET      = 5'd14,
    P_ZERO_TOG      = 5'd15,
    P_ONESET_RDCLR  = 5'd16,
    P_ONECLR_RDSET  = 5'd17,
    P_ZEROSET_RDCLR = 5'd18,
    P_ZEROCLR_RDSET = 5'd19,
    P_WRONLY        = 5'd20,
    P_WRONLY_ZEROS  = 5'd21,
    P_WRONLY_ONES   = 5'd22,
    P_ONCE          = 5'd23,
    P_WRONLY_ONCE   = 5'd24,
    P_NOACCESS      = 5'd25
  } policy_e;

  typedef enum logic [1:0] {
    RIGHTS_FULL   = 2'd0,
    RIGHTS_RDONLY = 2'd1,
    RIGHTS_WRONLY = 2'd2,
    RIGHTS_NONE   = 2'd3
  } rights_e;

  typedef enum logic [3:0] {
    OP_LOAD, OP_ZEROS, OP_ONES,
    OP_CLR1, OP_SET1, OP_TOG1,
    OP_CLR0, OP_SET0, OP_TOG0
  } wrOp_e;

  typedef struct packed {
    logic  wrAllowed;
    wrOp_e wrOp;
    logic  onceOnly;
    logic  rdVisible;
    logic  rdClear;
    logic  rdSet;
  } fieldCtl_t;

endpackage

// File: rtl/mpf_ctrl.sv
module mpf_ctrl
  import mpf_pkg::*;
(
  input  logic [POL_W-1:0] polSel,
  input  logic [1:0]       rights,
  output fieldCtl_t        ctl,
  output logic             illegalPolicy
);

  policy_e basePol;
  policy_e effPol;

  assign illegalPolicy = (polSel >= POL_W'(NUM_POLICIES));

  always_comb begin
    basePol = illegalPolicy ? P_RDWR : policy_e'(polSel);
  end

  // narrowing by the rights of the bus carrying the access
  always_comb begin
    effPol = basePol;
    case (rights_e'(rights))
      RIGHTS_FULL: effPol = basePol;
      RIGHTS_RDONLY: begin
        case (basePol)
          P_RDCLR, P_WR_RDCLR, P_ONES_RDCLR, P_ONESET_RDCLR, P_ZEROSET_RDCLR:
            effPol = P_RDCLR;
          P_RDSET, P_WR_RDSET, P_ZEROS_RDSET, P_ONECLR_RDSET, P_ZEROCLR_RDSET:
            effPol = P_RDSET;
          P_WRONLY, P_WRONLY_ZEROS, P_WRONLY_ONES, P_WRONLY_ONCE:
            effPol = P_NOACCESS;
          default: effPol = P_RDONLY;
        endcase
      end
      RIGHTS_WRONLY: begin
        case (basePol)
          P_RDWR, P_WR_RDCLR, P_WR_RDSET: effPol = P_WRONLY;
          P_ONESET_RDCLR:                 effPol = P_ONE_SET;
          P_ZEROSET_RDCLR:                effPol = P_ZERO_SET;
          P_ONECLR_RDSET:                 effPol = P_ONE_CLR;
          P_ZEROCLR_RDSET:                effPol = P_ZERO_CLR;
          P_ZEROS_RDSET:                  effPol = P_WRZEROS;
          P_ONES_RDCLR:                   effPol = P_WRONES;
          P_RDONLY, P_RDCLR, P_RDSET:     effPol = P_NOACCESS;
          default:                        effPol = basePol;
        endcase
      end
      default: effPol = P_NOACCESS;
    endcase
  end

  // strobe generation from the effective policy
  always_comb begin
    ctl.wrAllowed = 1'b1;
    ctl.wrOp      = OP_LOAD;
    ctl.onceOnly  = 1'b0;
    ctl.rdVisible = 1'b1;
    ctl.rdClear   = 1'b0;
    ctl.rdSet     = 1'b0;
    case (effPol)
      P_RDONLY, P_NOACCESS, P_RDCLR, P_RDSET: ctl.wrAllowed = 1'b0;
      P_WRZEROS, P_ZEROS_RDSET, P_WRONLY_ZEROS: ctl.wrOp = OP_ZEROS;
      P_WRONES, P_ONES_RDCLR, P_WRONLY_ONES:    ctl.wrOp = OP_ONES;
      P_ONE_CLR, P_ONECLR_RDSET:    ctl.wrOp = OP_CLR1;
      P_ONE_SET, P_ONESET_RDCLR:    ctl.wrOp = OP_SET1;
      P_ONE_TOG:                    ctl.wrOp = OP_TOG1;
      P_ZERO_CLR, P_ZEROCLR_RDSET:  ctl.wrOp = OP_CLR0;
      P_ZERO_SET, P_ZEROSET_RDCLR:  ctl.wrOp = OP_SET0;
      P_ZERO_TOG:                   ctl.wrOp = OP_TOG0;
      default:                      ctl.wrOp = OP_LOAD;
    endcase
    case (effPol)
      P_RDCLR, P_WR_RDCLR, P_ONES_RDCLR, P_ONESET_RDCLR, P_ZEROSET_RDCLR:
        ctl.rdClear = 1'b1;
      P_RDSET, P_WR_RDSET, P_ZEROS_RDSET, P_ONECLR_RDSET, P_ZEROCLR_RDSET:
        ctl.rdSet = 1'b1;
      default: ;
    endcase
    case (effPol)
      P_WRONLY, P_WRONLY_ZEROS, P_WRONLY_ONES, P_WRONLY_ONCE, P_NOACCESS:
        ctl.rdVisible = 1'b0;
      default: ;
    endcase
    ctl.onceOnly = (effPol == P_ONCE) || (effPol == P_WRONLY_ONCE);
  end

endmodule

// File: rtl/mpf_datapath.sv
module mpf_datapath
  import mpf_pkg::*;
#(
  parameter int unsigned       WIDTH     = 8,
  parameter logic [WIDTH-1:0]  RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  fieldCtl_t        ctl,
  input  logic             wrStb,
  input  logic [WIDTH-1:0] wrData,
  input  logic             wrByteEn,
  input  logic             rdStb,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] fieldValue
);

  logic [WIDTH-1:0] curVal;
  logic [WIDTH-1:0] afterRd;
  logic [WIDTH-1:0] wrResult;
  logic [WIDTH-1:0] nxtVal;
  logic             writtenOnce;
  logic             wrReach;
  logic             wrApply;

  assign wrReach = wrStb && wrByteEn && ctl.wrAllowed;
  assign wrApply = wrReach && !(ctl.onceOnly && writtenOnce);

  assign rdData     = (rdStb && ctl.rdVisible) ? curVal : '0;
  assign fieldValue = curVal;

  always_comb begin
    afterRd = curVal;
    if (rdStb && ctl.rdClear)    afterRd = '0;
    else if (rdStb && ctl.rdSet) afterRd = '1;
  end

  always_comb begin
    case (ctl.wrOp)
      OP_LOAD:  wrResult = wrData;
      OP_ZEROS: wrResult = '0;
      OP_ONES:  wrResult = '1;
      OP_CLR1:  wrResult = afterRd & ~wrData;
      OP_SET1:  wrResult = afterRd | wrData;
      OP_TOG1:  wrResult = afterRd ^ wrData;
      OP_CLR0:  wrResult = afterRd & wrData;
      OP_SET0:  wrResult = afterRd | ~wrData;
      OP_TOG0:  wrResult = afterRd ^ ~wrData;
      default:  wrResult = afterRd;
    endcase
    nxtVal = wrApply ? wrResult : afterRd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curVal      <= RESET_VAL;
      writtenOnce <= 1'b0;
    end else begin
      curVal <= nxtVal;
      if (wrReach) writtenOnce <= 1'b1;
    end
  end

endmodule

// File: rtl/multi_policy_field.sv
module multi_policy_field
  import mpf_pkg::*;
#(
  parameter int unsigned      WIDTH     = 8,
  parameter logic [WIDTH-1:0] RESET_VAL = 8'hA5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [4:0]       polSel,
  input  logic [1:0]       rights,
  input  logic             wrStb,
  input  logic [WIDTH-1:0] wrData,
  input  logic             wrByteEn,
  input  logic             rdStb,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] fieldValue,
  output logic             illegalPolicy
);

  generate
    if (WIDTH < 1) begin : g_badWidth
      $error("multi_policy_field: WIDTH must be at least 1");
    end
  endgenerate

  fieldCtl_t ctl;

  mpf_ctrl u_ctrl (
    .polSel        (polSel),
    .rights        (rights),
    .ctl           (ctl),
    .illegalPolicy (illegalPolicy)
  );

  mpf_datapath #(.WIDTH(WIDTH), .RESET_VAL(RESET_VAL)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .wrStb      (wrStb),
    .wrData     (wrData),
    .wrByteEn   (wrByteEn),
    .rdStb      (rdStb),
    .rdData     (rdData),
    .fieldValue (fieldValue)
  );

endmodule

// File: rtl/mpf_checker.sv
module mpf_checker #(
  parameter int unsigned      WIDTH     = 8,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input logic             clk,
  input logic             rst,
  input logic [4:0]       polSel,
  input logic [1:0]       rights,
  input logic             wrStb,
  input logic [WIDTH-1:0] wrData,
  input logic             wrByteEn,
  input logic             rdStb,
  input logic [WIDTH-1:0] rdData,
  input logic [WIDTH-1:0] fieldValue,
  input logic             illegalPolicy
);

  logic hiddenPol;
  logic rdClrPol;
  logic rdSetPol;
  assign hiddenPol = (polSel == 5'd20) || (polSel == 5'd21) ||
                     (polSel == 5'd22) || (polSel == 5'd24);
  assign rdClrPol  = (polSel == 5'd2) || (polSel == 5'd6) || (polSel == 5'd8) ||
                     (polSel == 5'd16) || (polSel == 5'd18);
  assign rdSetPol  = (polSel == 5'd3) || (polSel == 5'd7) || (polSel == 5'd9) ||
                     (polSel == 5'd17) || (polSel == 5'd19);

  p_reset_value_r1: assert property (@(posedge clk)
    rst |=> fieldValue == RESET_VAL);

  p_ro_rights_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (rights == 2'd1 && !rdStb) |=> $stable(fieldValue));

  p_no_byteen_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!(wrStb && wrByteEn) && !rdStb) |=> $stable(fieldValue));

  p_hidden_read_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (!rdStb || hiddenPol || rights == 2'd3) |-> rdData == '0);

  p_read_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (rdStb && !wrStb && rights == 2'd0 && rdClrPol) |=> fieldValue == '0);

  p_read_sets_r5: assert property (@(posedge clk) disable iff (rst)
    (rdStb && !wrStb && rights == 2'd0 && rdSetPol) |=> fieldValue == '1);

  p_illegal_as_rw_r10: assert property (@(posedge clk) disable iff (rst)
    (illegalPolicy && rights == 2'd0 && wrStb && wrByteEn && !rdStb)
      |=> fieldValue == $past(wrData));

  p_read_pre_value_r12: assert property (@(posedge clk) disable iff (rst)
    (rdStb && rights == 2'd0 && polSel == 5'd0) |-> rdData == fieldValue);

endmodule

bind multi_policy_field mpf_checker #(.WIDTH(WIDTH), .RESET_VAL(RESET_VAL)) u_chk (.*);

// File: tb/multi_policy_field_test.sv
module multi_policy_field_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] polSel = '0;
  logic [1:0] rights = '0;
  logic       wrStb = 1'b0;
  logic [7:0] wrData = '0;
  logic       wrByteEn = 1'b0;
  logic       rdStb = 1'b0;
  logic [7:0] rdData;
  logic [7:0] fieldValue;
  logic       illegalPolicy;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  multi_policy_field #(.WIDTH(8), .RESET_VAL(8'hA5)) uut (
    .clk(clk), .rst(rst), .polSel(polSel), .rights(rights),
    .wrStb(wrStb), .wrData(wrData), .wrByteEn(wrByteEn), .rdStb(rdStb),
    .rdData(rdData), .fieldValue(fieldValue), .illegalPolicy(illegalPolicy)
  );

  typedef struct packed {
    logic [7:0] pre;
    logic [4:0] pol;
    logic [1:0] rgt;
    logic       wr;
    logic       be;
    logic [7:0] wd;
    logic       rd;
    logic [7:0] expRd;
    logic [7:0] expVal;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VECS [NV] = '{
    '{8'h3C, 5'd0,  2'd0, 1'b1, 1'b1, 8'h5A, 1'b0, 8'h00, 8'h5A, 4'd2},  // R2
    '{8'h3C, 5'd4,  2'd0, 1'b1, 1'b1, 8'hFF, 1'b0, 8'h00, 8'h00, 4'd2},  // R2
    '{8'h3C, 5'd22, 2'd0, 1'b1, 1'b1, 8'h00, 1'b0, 8'h00, 8'hFF, 4'd2},  // R2
    '{8'hF0, 5'd10, 2'd0, 1'b1, 1'b1, 8'h30, 1'b0, 8'h00, 8'hC0, 4'd3},  // R3
    '{8'h0F, 5'd11, 2'd0, 1'b1, 1'b1, 8'h30, 1'b0, 8'h00, 8'h3F, 4'd3},  // R3
    '{8'hAA, 5'd12, 2'd0, 1'b1, 1'b1, 8'h0F, 1'b0, 8'h00, 8'hA5, 4'd3},  // R3
    '{8'hF0, 5'd13, 2'd0, 1'b1, 1'b1, 8'h3C, 1'b0, 8'h00, 8'h30, 4'd3},  // R3
    '{8'h0F, 5'd14, 2'd0, 1'b1, 1'b1, 8'h3C, 1'b0, 8'h00, 8'hCF, 4'd3},  // R3
    '{8'hAA, 5'd15, 2'd0, 1'b1, 1'b1, 8'h0F, 1'b0, 8'h00, 8'h5A, 4'd3},  // R3
    '{8'h0F, 5'd16, 2'd0, 1'b1, 1'b1, 8'h30, 1'b0, 8'h00, 8'h3F, 4'd4},  // R4
    '{8'h3F, 5'd16, 2'd0, 1'b0, 1'b0, 8'h00, 1'b1, 8'h3F, 8'h00, 4'd5},  // R5
    '{8'hF0, 5'd17, 2'd0, 1'b0, 1'b0, 8'h00, 1'b1, 8'hF0, 8'hFF, 4'd5},  // R5
    '{8'h0F, 5'd18, 2'd0, 1'b1, 1'b1, 8'h3C, 1'b0, 8'h00, 8'hCF, 4'd4},  // R4
    '{8'hF0, 5'd19, 2'd0, 1'b1, 1'b1, 8'h3C, 1'b0, 8'h00, 8'h30, 4'd4},  // R4
    '{8'h12, 5'd8,  2'd0, 1'b1, 1'b1, 8'h00, 1'b0, 8'h00, 8'hFF, 4'd4},  // R4
    '{8'h12, 5'd9,  2'd0, 1'b1, 1'b1, 8'hFF, 1'b0, 8'h00, 8'h00, 4'd4},  // R4
    '{8'h5A, 5'd2,  2'd0, 1'b1, 1'b1, 8'hFF, 1'b1, 8'h5A, 8'h00, 4'd5},  // R5
    '{8'h5A, 5'd3,  2'd0, 1'b0, 1'b0, 8'h00, 1'b1, 8'h5A, 8'hFF, 4'd5},  // R5
    '{8'h5A, 5'd1,  2'd0, 1'b1, 1'b1, 8'h00, 1'b1, 8'h5A, 8'h5A, 4'd5},  // R5
    '{8'h5A, 5'd6,  2'd0, 1'b1, 1'b1, 8'h77, 1'b1, 8'h5A, 8'h77, 4'd12}, // R12
    '{8'h5A, 5'd7,  2'd0, 1'b0, 1'b0, 8'h00, 1'b1, 8'h5A, 8'hFF, 4'd5},  // R5
    '{8'h5A, 5'd20, 2'd0, 1'b0, 1'b0, 8'h00, 1'b1, 8'h00, 8'h5A, 4'd7},  // R7
    '{8'h5A, 5'd21, 2'd0, 1'b0, 1'b0, 8'h00, 1'b1, 8'h00, 8'h5A, 4'd7},  // R7
    '{8'h5A, 5'd17, 2'd0, 1'b1, 1'b1, 8'h0F, 1'b1, 8'h5A, 8'hF0, 4'd12}, // R12
    '{8'h5A, 5'd0,  2'd1, 1'b1, 1'b1, 8'h00, 1'b0, 8'h00, 8'h5A, 4'd8},  // R8
    '{8'h5A, 5'd6,  2'd1, 1'b0, 1'b0, 8'h00, 1'b1, 8'h5A, 8'h00, 4'd8},  // R8
    '{8'h5A, 5'd19, 2'd1, 1'b0, 1'b0, 8'h00, 1'b1, 8'h5A, 8'hFF, 4'd8},  // R8
    '{8'h5A, 5'd21, 2'd1, 1'b1, 1'b1, 8'h00, 1'b1, 8'h00, 8'h5A, 4'd8},  // R8
    '{8'h5A, 5'd16, 2'd1, 1'b1, 1'b1, 8'hFF, 1'b0, 8'h00, 8'h5A, 4'd8},  // R8
    '{8'h5A, 5'd6,  2'd2, 1'b0, 1'b0, 8'h00, 1'b1, 8'h00, 8'h5A, 4'd9},  // R9
    '{8'h0F, 5'd16, 2'd2, 1'b1, 1'b1, 8'h30, 1'b1, 8'h0F, 8'h3F, 4'd9},  // R9
    '{8'h5A, 5'd1,  2'd2, 1'b0, 1'b0, 8'h00, 1'b1, 8'h00, 8'h5A, 4'd9},  // R9
    '{8'h5A, 5'd0,  2'd3, 1'b1, 1'b1, 8'h00, 1'b1, 8'h00, 8'h5A, 4'd9},  // R9
    '{8'h3C, 5'd0,  2'd0, 1'b1, 1'b0, 8'hFF, 1'b0, 8'h00, 8'h3C, 4'd11}, // R11
    '{8'h3C, 5'd11, 2'd0, 1'b1, 1'b0, 8'hFF, 1'b0, 8'h00, 8'h3C, 4'd11}, // R11
    '{8'h3C, 5'd27, 2'd0, 1'b1, 1'b1, 8'h81, 1'b1, 8'h3C, 8'h81, 4'd10}, // R10
    '{8'h3C, 5'd31, 2'd1, 1'b1, 1'b1, 8'h81, 1'b0, 8'h00, 8'h3C, 4'd10}  // R10
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    polSel = '0; rights = '0; wrStb = 1'b0; wrByteEn = 1'b0; wrData = '0; rdStb = 1'b0;
  endtask

  // one access cycle; returns after the following edge with inputs idle
  task automatic doOp(input logic [4:0] p, input logic [1:0] r, input logic w,
                      input logic [7:0] d, input logic rd, output logic [7:0] rdv);
    @(negedge clk);
    polSel = p; rights = r; wrStb = w; wrByteEn = w; wrData = d; rdStb = rd;
    #1 rdv = rdData;
    @(negedge clk);
    idle();
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    idle();
    @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1", fieldValue, 8'hA5);
    chk("R7", rdData, 8'h00);
    chk("R10", {7'd0, illegalPolicy}, 8'h00);

    // write-once, readable variant
    doOp(5'd23, 2'd0, 1'b1, 8'h11, 1'b0, rv);
    chk("R6", fieldValue, 8'h11);
    doOp(5'd23, 2'd0, 1'b1, 8'h22, 1'b0, rv);
    chk("R6", fieldValue, 8'h11);
    doOp(5'd23, 2'd0, 1'b0, 8'h00, 1'b1, rv);
    chk("R6", rv, 8'h11);
    doReset();
    chk("R1", fieldValue, 8'hA5);
    doOp(5'd23, 2'd0, 1'b1, 8'h33, 1'b0, rv);
    chk("R1", fieldValue, 8'h33);

    // write-once, write-only variant
    doReset();
    doOp(5'd24, 2'd0, 1'b1, 8'h44, 1'b0, rv);
    chk("R6", fieldValue, 8'h44);
    doOp(5'd24, 2'd0, 1'b1, 8'h55, 1'b0, rv);
    chk("R6", fieldValue, 8'h44);
    doOp(5'd24, 2'd0, 1'b0, 8'h00, 1'b1, rv);
    chk("R7", rv, 8'h00);
    chk("R7", fieldValue, 8'h44);

    // vector table: preload, one access, check
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      @(negedge clk);
      polSel = 5'd0; rights = 2'd0; wrStb = 1'b1; wrByteEn = 1'b1;
      wrData = VECS[i].pre; rdStb = 1'b0;
      @(negedge clk);
      polSel = VECS[i].pol; rights = VECS[i].rgt; wrStb = VECS[i].wr;
      wrByteEn = VECS[i].be; wrData = VECS[i].wd; rdStb = VECS[i].rd;
      #1;
      chk("R12", fieldValue, VECS[i].pre);
      chk("R10", {7'd0, illegalPolicy}, {7'd0, (VECS[i].pol >= 5'd25)});
      if (VECS[i].rd) chk(tag, rdData, VECS[i].expRd);
      @(negedge clk);
      idle();
      #1;
      chk(tag, fieldValue, VECS[i].expVal);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule